// File: doc/BRIEF.md
# Cartridge Wait-State Timing Generator

This block works out how long each bus access to the memory map takes and marks the end of every access with a pulse. It holds a 16-bit timing control word. From that word it builds wait counts for three cartridge ROM windows and the battery-backed SRAM window. Internal regions use fixed timing.

A requester presents an access by giving its region number (the top nibble of the address), its width, whether it is sequential, whether it writes, and whether it is an instruction fetch. The block accepts the access when it is idle. It then counts the full access time down and raises `beat_done` for one cycle when the access completes.

A burst request moves several 32-bit words. Its first word is timed as non-sequential and every later word as sequential. There is one `beat_done` per word, and `last_beat` marks the final word. The timing of an access is fixed at the cycle it is accepted. A later write to the control word affects only accesses that start after that write.

Top module: `cart_wait_timer`

## Requirements
- R1: After reset the block is idle, `beat_done` and `last_beat` are low, and the control word is zero.
- R2: A first-access field code of 0, 1, 2 or 3 gives 4, 3, 2 or 8 wait cycles. The window 0 field is control bits [3:2], window 1 is bits [6:5], and window 2 is bits [9:8]. Window 0 is regions 8 and 9, window 1 is regions 10 and 11, and window 2 is regions 12 and 13.
- R3: The sequential bit of a window is bit 4 for window 0, bit 7 for window 1 and bit 10 for window 2. When the bit is 1 the sequential 16-bit wait is 1. When it is 0 the wait is 2, 4 or 8 for windows 0, 1 and 2.
- R4: For a ROM window, a 32-bit sequential wait is twice the 16-bit sequential wait plus one. A 32-bit non-sequential wait is the 16-bit first-access wait plus one plus the 16-bit sequential wait.
- R5: Regions 14 and 15 use control bits [1:0] with the same code mapping as R2, for both sequential and non-sequential accesses. A 32-bit access there waits twice that value plus one.
- R6: A single read takes 2 cycles plus its wait, and a single write takes 1 cycle plus its wait. The cycle count runs from the accepting clock edge to the `beat_done` cycle.
- R7: Region 2 waits 2 for 16-bit accesses and 5 for 32-bit accesses. Regions 0, 1 and 3 to 7 wait 0.
- R8: When control bit 14 is set, instruction fetches (`req_fetch` = 1) from regions 8 to 13 wait 0. Data accesses keep their normal waits. When the bit is clear, fetches keep their normal waits.
- R9: A request with `req_beats` greater than 1 is a burst of 32-bit words. The first word takes 1 plus the non-sequential 32-bit wait. Each later word takes 1 plus the sequential 32-bit wait. `last_beat` is high together with the final `beat_done` only.
- R10: A control word write changes the timing of accesses accepted after the write edge only. Accesses and bursts already running keep their latched timing.
- R11: `beat_done` is high for exactly one cycle per word, and `idle` is low from acceptance until the last word completes. A request presented while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing control word |
| cfg_wdata | input | 16 | New timing control word |
| req_valid | input | 1 | Access request, taken when `idle` is high |
| req_region | input | 4 | Region number of the access |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access (single accesses) |
| req_seq | input | 1 | 1 = sequential access (single accesses) |
| req_write | input | 1 | 1 = write, 0 = read (single accesses) |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_beats | input | BEAT_W | Word count; 0 or 1 = single access, more = burst |
| idle | output | 1 | Block can accept a request |
| beat_done | output | 1 | One-cycle pulse at the end of each word |
| last_beat | output | 1 | High with the final `beat_done` of an access |

## Verification
The bench builds the block with its default parameters: a 6-bit cycle counter and an 8-bit beat count. These widths cover the longest single access, a 19-cycle 32-bit non-sequential read from window 2, and bursts of several words. With these values the bench can run:
- every field code on every window and on SRAM;
- bursts whose words finish on back-to-back cycles in zero-wait regions;
- control writes that land in the middle of a long access or a burst.

// File: rtl/cwt_pkg.sv
`timescale 1ns/1ps
package cwt_pkg;

    localparam int CFG_W        = 16;
    localparam int REGION_W     = 4;
    localparam int WAIT_W       = 5;
    localparam int ROM_WINDOWS  = 3;
    // control word layout (decoded by software, so positions are fixed)
    localparam int FIRST_LO     = 2;
    localparam int SEQ_BIT0     = 4;
    localparam int FIELD_STRIDE = 3;
    localparam int PF_BIT       = 14;
    // region numbering
    localparam logic [REGION_W-1:0] EXT_RAM_REGION = 4'd2;
    localparam logic [REGION_W-1:0] ROM_BASE       = 4'd8;
    localparam logic [REGION_W-1:0] SRAM_BASE      = ROM_BASE + 4'(2 * ROM_WINDOWS);

    typedef struct packed {
        logic [WAIT_W-1:0] n16;
        logic [WAIT_W-1:0] s16;
        logic [WAIT_W-1:0] n32;
        logic [WAIT_W-1:0] s32;
    } wait_set_t;

    localparam wait_set_t EXT_RAM_SET = '{n16: 5'd2, s16: 5'd2, n32: 5'd5, s32: 5'd5};

    function automatic logic [WAIT_W-1:0] first_wait(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd4;
            2'd1:    return 5'd3;
            2'd2:    return 5'd2;
            default: return 5'd8;
        endcase
    endfunction

    function automatic wait_set_t rom_timing(input int win, input logic [1:0] code,
                                             input logic seq_fast);
        wait_set_t t;
        logic [WAIT_W-1:0] s;
        s     = seq_fast ? 5'd1 : WAIT_W'(2 << win);
        t.n16 = first_wait(code);
        t.s16 = s;
        t.n32 = t.n16 + s + 5'd1;
        t.s32 = (s << 1) + 5'd1;
        return t;
    endfunction

    function automatic wait_set_t sram_timing(input logic [1:0] code);
        wait_set_t t;
        t.n16 = first_wait(code);
        t.s16 = t.n16;
        t.n32 = (t.n16 << 1) + 5'd1;
        t.s32 = t.n32;
        return t;
    endfunction

endpackage

// File: rtl/cwt_cfg_reg.sv
`timescale 1ns/1ps
module cwt_cfg_reg
    import cwt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output wait_set_t [ROM_WINDOWS-1:0]   rom_sets,
    output wait_set_t                     sram_set,
    output logic                          prefetch_en
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    for (genvar k = 0; k < ROM_WINDOWS; k++) begin : g_win
        assign rom_sets[k] = rom_timing(k, cfg_q[FIRST_LO + FIELD_STRIDE*k +: 2],
                                        cfg_q[SEQ_BIT0 + FIELD_STRIDE*k]);
    end

    assign sram_set    = sram_timing(cfg_q[1:0]);
    assign prefetch_en = cfg_q[PF_BIT];

    // R10
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_q == $past(cfg_wdata));

endmodule

// File: rtl/cwt_lookup.sv
`timescale 1ns/1ps
module cwt_lookup
    import cwt_pkg::*;
(
    input  wait_set_t [ROM_WINDOWS-1:0] rom_sets,
    input  wait_set_t                   sram_set,
    input  logic                        prefetch_en,
    input  logic [REGION_W-1:0]         region,
    input  logic                        fetch,
    output wait_set_t                   region_set
);

    logic [1:0] win_idx;
    logic       in_rom;

    assign in_rom  = (region >= ROM_BASE) && (region < SRAM_BASE);
    assign win_idx = 2'((region - ROM_BASE) >> 1);

    always_comb begin
        region_set = '0;
        if (region == EXT_RAM_REGION) begin
            region_set = EXT_RAM_SET;
        end else if (in_rom) begin
            if (!(fetch && prefetch_en) && (int'(win_idx) < ROM_WINDOWS))
                region_set = rom_sets[win_idx];
        end else if (region >= SRAM_BASE) begin
            region_set = sram_set;
        end
    end

    always_comb begin
        // R7
        if (region < ROM_BASE && region != EXT_RAM_REGION)
            fixed_zero_chk: assert (region_set == '0);
        // R8
        if (in_rom && fetch && prefetch_en)
            prefetch_zero_chk: assert (region_set.n32 == '0 && region_set.s16 == '0);
    end

endmodule

// File: rtl/cwt_sequencer.sv
`timescale 1ns/1ps
module cwt_sequencer
    import cwt_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic              req_seq,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats,
    input  wait_set_t         region_set,
    output logic              idle,
    output logic              beat_done,
    output logic              last_beat
);

    logic              busy, accept, burst;
    logic [CNT_W-1:0]  cnt, next_cost, first_cost, seq_cost;
    logic [BEAT_W-1:0] beats_left;
    logic [WAIT_W-1:0] single_wait;

    always_comb begin
        burst = req_beats > BEAT_W'(1);
        if (req_wide) single_wait = req_seq ? region_set.s32 : region_set.n32;
        else          single_wait = req_seq ? region_set.s16 : region_set.n16;
        first_cost = burst ? CNT_W'(region_set.n32) + CNT_W'(1)
                           : CNT_W'(single_wait) + (req_write ? CNT_W'(1) : CNT_W'(2));
        seq_cost   = CNT_W'(region_set.s32) + CNT_W'(1);
    end

    assign accept    = req_valid && !busy;
    assign idle      = !busy;
    assign beat_done = busy && (cnt == CNT_W'(1));
    assign last_beat = beat_done && (beats_left == BEAT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cnt        <= '0;
            next_cost  <= '0;
            beats_left <= '0;
        end else if (accept) begin
            busy       <= 1'b1;
            cnt        <= first_cost;
            next_cost  <= seq_cost;
            beats_left <= burst ? req_beats : BEAT_W'(1);
        end else if (busy) begin
            if (cnt == CNT_W'(1)) begin
                if (beats_left == BEAT_W'(1)) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= next_cost;
                end
                beats_left <= beats_left - BEAT_W'(1);
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !idle);
    // R9
    last_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_done && last_beat) |=> idle);
    // R9
    burst_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_done && !last_beat) |=> !idle);
    // R10
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat_done) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/cart_wait_timer.sv
`timescale 1ns/1ps
module cart_wait_timer
    import cwt_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [3:0]        req_region,
    input  logic              req_wide,
    input  logic              req_seq,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [BEAT_W-1:0] req_beats,
    output logic              idle,
    output logic              beat_done,
    output logic              last_beat
);

    wait_set_t [ROM_WINDOWS-1:0] rom_sets;
    wait_set_t                   sram_set;
    wait_set_t                   region_set;
    logic                        prefetch_en;

    cwt_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .rom_sets   (rom_sets),
        .sram_set   (sram_set),
        .prefetch_en(prefetch_en)
    );

    cwt_lookup u_lookup (
        .rom_sets   (rom_sets),
        .sram_set   (sram_set),
        .prefetch_en(prefetch_en),
        .region     (req_region),
        .fetch      (req_fetch),
        .region_set (region_set)
    );

    cwt_sequencer #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_wide  (req_wide),
        .req_seq   (req_seq),
        .req_write (req_write),
        .req_beats (req_beats),
        .region_set(region_set),
        .idle      (idle),
        .beat_done (beat_done),
        .last_beat (last_beat)
    );

endmodule

// File: tb/cart_wait_timer_test.sv
`timescale 1ns/1ps
module cart_wait_timer_test;

    localparam int BEAT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [15:0]       cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [3:0]        req_region = '0;
    logic              req_wide = 1'b0, req_seq = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [BEAT_W-1:0] req_beats = '0;
    logic              idle, beat_done, last_beat;

    always #2 clk = ~clk;

    cart_wait_timer #(.CNT_W(6), .BEAT_W(BEAT_W)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
        .req_seq(req_seq), .req_write(req_write), .req_fetch(req_fetch),
        .req_beats(req_beats), .idle(idle), .beat_done(beat_done), .last_beat(last_beat)
    );

    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] cur_cfg = '0;
    int          exp_q[$];
    bit          last_q[$];
    string       tag_q[$];
    int          m_e;
    bit          m_l;
    string       m_s;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && beat_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 beat with nothing pending", cyc, -1);
            end else begin
                m_e = exp_q.pop_front();
                m_l = last_q.pop_front();
                m_s = tag_q.pop_front();
                check(cyc == m_e, m_s, cyc, m_e);
                check(last_beat == m_l, {m_s, " last flag"}, int'(last_beat), int'(m_l));
            end
        end
    end

    function automatic int wfirst(input logic [1:0] c);
        return (c == 2'd3) ? 8 : 4 - int'(c);
    endfunction

    function automatic int wseq(input int w, input logic b);
        if (b) return 1;
        return (w == 0) ? 2 : (w == 1) ? 4 : 8;
    endfunction

    function automatic int exp_wait(input logic [15:0] c, input int rg, input bit wide,
                                    input bit seq, input bit fet);
        int w, f, s, x;
        if (rg == 2) return wide ? 5 : 2;
        if (rg >= 8 && rg <= 13) begin
            w = (rg - 8) / 2;
            if (fet && c[14]) return 0;
            f = wfirst(c[2 + 3*w +: 2]);
            s = wseq(w, c[4 + 3*w]);
            if (!wide) return seq ? s : f;
            return seq ? 2*s + 1 : f + 1 + s;
        end
        if (rg >= 14) begin
            x = wfirst(c[1:0]);
            return wide ? 2*x + 1 : x;
        end
        return 0;
    endfunction

    // driver: issues one access and pushes its expected beat cycles
    task automatic start(input int rg, input bit wide, input bit seq, input bit wr,
                         input bit fet, input int beats, input string tag);
        int a, t;
        @(negedge clk);
        while (!idle) @(negedge clk);
        req_valid = 1'b1; req_region = 4'(rg); req_wide = wide; req_seq = seq;
        req_write = wr; req_fetch = fet; req_beats = BEAT_W'(beats);
        @(posedge clk); #1;
        a = cyc;
        req_valid = 1'b0;
        if (beats > 1) begin
            t = a - 1 + 1 + exp_wait(cur_cfg, rg, 1'b1, 1'b0, fet);
            exp_q.push_back(t); last_q.push_back(1'b0); tag_q.push_back(tag);
            for (int b = 1; b < beats; b++) begin
                t = t + 1 + exp_wait(cur_cfg, rg, 1'b1, 1'b1, fet);
                exp_q.push_back(t); last_q.push_back(b == beats - 1); tag_q.push_back(tag);
            end
        end else begin
            t = a - 1 + (wr ? 1 : 2) + exp_wait(cur_cfg, rg, wide, seq, fet);
            exp_q.push_back(t); last_q.push_back(1'b1); tag_q.push_back(tag);
        end
    endtask

    task automatic drain(input string tag);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(idle == 1'b1, {tag, " idle after completion"}, int'(idle), 1);
    endtask

    task automatic acc(input int rg, input bit wide, input bit seq, input bit wr,
                       input bit fet, input int beats, input string tag);
        start(rg, wide, seq, wr, fet, beats, tag);
        drain(tag);
    endtask

    task automatic wcfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        cur_cfg = v;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(idle == 1'b1, "R1 idle", int'(idle), 1);
        check(beat_done == 1'b0, "R1 beat_done", int'(beat_done), 0);
        check(last_beat == 1'b0, "R1 last_beat", int'(last_beat), 0);
        acc(8, 0, 0, 0, 0, 1, "R1 zero control word timing");
        acc(13, 1, 0, 0, 0, 1, "R1 zero control word window 2");

        // R2 first-access codes
        for (int c = 0; c < 4; c++) begin
            wcfg(16'(c << 2));
            acc(9, 0, 0, 0, 0, 1, "R2 window0 code");
        end
        wcfg(16'(2 << 5));  acc(10, 0, 0, 0, 0, 1, "R2 window1 code 2");
        wcfg(16'(3 << 8));  acc(12, 0, 0, 0, 0, 1, "R2 window2 code 3");
        wcfg(16'(1 << 5));  acc(11, 0, 0, 0, 0, 1, "R2 window1 code 1");

        // R3 sequential bits
        for (int w = 0; w < 3; w++) begin
            for (int b = 0; b < 2; b++) begin
                wcfg(16'(b << (4 + 3*w)));
                acc(8 + 2*w, 0, 1, 0, 0, 1, "R3 sequential 16-bit");
            end
        end

        // R4 32-bit derivation
        wcfg(16'h04B6);
        for (int w = 0; w < 3; w++) begin
            acc(8 + 2*w, 1, 1, 0, 0, 1, "R4 32-bit sequential");
            acc(9 + 2*w, 1, 0, 0, 0, 1, "R4 32-bit non-sequential");
        end
        wcfg(16'h0000);
        acc(12, 1, 0, 0, 0, 1, "R4 slowest window2 non-sequential");

        // R5 SRAM window
        for (int c = 0; c < 4; c++) begin
            wcfg(16'(c) | 16'h0394);
            acc(14, 0, 0, 0, 0, 1, "R5 sram 16-bit");
            acc(15, 0, 1, 0, 0, 1, "R5 sram 16-bit sequential");
            acc(15, 1, 0, 0, 0, 1, "R5 sram 32-bit");
        end

        // R6 read versus write
        wcfg(16'h0155);
        acc(13, 0, 0, 1, 0, 1, "R6 write window2");
        acc(13, 0, 0, 0, 0, 1, "R6 read window2");
        acc(3, 0, 0, 1, 0, 1, "R6 write zero-wait region");
        acc(2, 1, 0, 1, 0, 1, "R6 write region2 32-bit");

        // R7 fixed regions
        for (int r = 0; r < 8; r++) begin
            acc(r, 0, 0, 0, 0, 1, "R7 fixed 16-bit");
            acc(r, 1, 1, 0, 0, 1, "R7 fixed 32-bit");
        end

        // R8 prefetch
        wcfg(16'h4019);
        acc(9, 0, 0, 0, 1, 1, "R8 fetch with prefetch");
        acc(12, 1, 0, 0, 1, 1, "R8 fetch 32-bit with prefetch");
        acc(9, 0, 0, 0, 0, 1, "R8 data read with prefetch");
        acc(14, 0, 0, 0, 1, 1, "R8 sram fetch unaffected");
        acc(2, 0, 0, 0, 1, 1, "R8 region2 fetch unaffected");
        wcfg(16'h0019);
        acc(9, 0, 0, 0, 1, 1, "R8 fetch without prefetch");

        // R9 bursts
        acc(10, 0, 0, 0, 0, 4, "R9 burst window1");
        acc(3, 0, 0, 0, 0, 3, "R9 burst zero-wait back-to-back");
        acc(14, 0, 0, 0, 0, 2, "R9 burst sram");
        wcfg(16'h4000);
        acc(8, 0, 0, 0, 1, 3, "R9 burst fetch with prefetch");

        // R10 control write during access
        wcfg(16'h0000);
        start(13, 1, 0, 0, 0, 1, "R10 in-flight keeps old timing");
        wcfg(16'h0795);
        drain("R10");
        acc(13, 1, 0, 0, 0, 1, "R10 next access uses new timing");
        wcfg(16'h0000);
        start(12, 0, 0, 0, 0, 4, "R10 burst keeps old timing");
        wcfg(16'h0400);
        drain("R10 burst");

        // R11 request while busy is ignored
        wcfg(16'h0300);
        start(12, 1, 0, 0, 0, 1, "R11 long access");
        @(negedge clk);
        check(idle == 1'b0, "R11 busy during access", int'(idle), 0);
        req_valid = 1'b1; req_region = 4'd0; req_beats = BEAT_W'(1);
        @(negedge clk);
        req_valid = 1'b0;
        check(idle == 1'b0, "R11 still busy", int'(idle), 0);
        drain("R11");
        repeat (25) @(negedge clk);
        check(exp_q.size() == 0, "R11 no extra beats", exp_q.size(), 0);

        finish_run();
    end

endmodule